// File: doc/BRIEF.md
# Rule-Driven Link and Activity Indicator Controller

This block drives a small set of indicator outputs (three by default) from the live state of an Ethernet link. It takes the link-up flag, a two-bit speed code, a duplex flag and single-cycle pulses for transmit and receive traffic at each speed, collisions, receive CRC errors and receive idle errors. Firmware programs, through a plain write/read register port, which of these conditions light each indicator steadily and which start a blink burst.

Each indicator has two rule registers. The steady rule selects the link conditions that light it: speed match, link down, duplex, or an unconditional force-on. It also holds the enable and polarity controls. The blink rule selects the events that open a blink window, plus an unconditional force-blink. While a window is open, the indicator toggles with an on time and a period taken from two shared duration registers, counted in prescaled ticks. A shared control register gates every indicator globally.

Top module: `ledrule_ctrl`

## Requirements
- R1: Registers sit at 0x21 (control), 0x22 (on time), 0x23 (blink period), 0x24+2i (steady rule of indicator i) and 0x25+2i (blink rule of indicator i). A write to one of them takes effect on the next clock edge. Reads return the stored value with unused bits as zero: control keeps mask 0x800F, steady rules 0xC17F, blink rules 0x0FFF and durations all 16 bits. Any other address reads 0.
- R2: After reset, control and all rules are 0, the on time is 1024 and the blink period is 2048. Every pin then sits at its inactive level, which is high because polarity resets to 0.
- R3: An indicator can be lit only when control bit 15 (external control) and control bit 3 (tick clock enable) are both 1. Otherwise every pin sits at its inactive level.
- R4: Steady-rule bits 0, 1, 2 and 8 light the indicator when the link is up at speed code 2 (1000), 1 (100), 0 (10) and 3 (2500). Bit 3 lights it while the link is down. Bits 4 and 5 light it when the link is up at full or half duplex.
- R5: Steady-rule bit 6 lights the indicator whatever the link state.
- R6: Blink-rule bits 0/1, 2/3, 4/5 and 10/11 select the TX/RX event pulses of speed index 2, 1, 0 and 3. Bits 6, 7 and 8 select the collision, CRC-error and idle-error pulses. A selected pulse opens a blink window from the next cycle. An unselected pulse has no effect.
- R7: A window that opens while none is open starts its phase at 0. In a window the indicator is lit while the phase count is below the on time. The phase advances once per tick and wraps to 0 when it reaches the blink period. While the window is open it overrides the steady level.
- R8: Each selected event restarts a count of ticks. When that count reaches the blink period with no further event, the window closes and the indicator returns to its steady level.
- R9: Blink-rule bit 9 holds a blink window open for as long as it is set.
- R10: Steady-rule bit 15 enables the indicator. Bit 14 picks the polarity: 1 drives the lit state high, 0 drives it low. A disabled indicator always drives its inactive level.
- R11: While control bit 3 is 1, one tick occurs every PRESCALE clock cycles. While it is 0, the prescaler is held at its start and no tick occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register address for write and read |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data of the addressed register (combinational) |
| link_up | input | 1 | Link is established |
| link_speed | input | 2 | Speed code: 0=10, 1=100, 2=1000, 3=2500 |
| full_duplex | input | 1 | Link runs full duplex |
| tx_evt | input | 4 | Transmit pulse per speed index |
| rx_evt | input | 4 | Receive pulse per speed index |
| col_evt | input | 1 | Collision pulse |
| crc_err_evt | input | 1 | Receive CRC error pulse |
| idle_err_evt | input | 1 | Receive idle error pulse |
| led_pin | output | NUM_LED | Physical indicator levels |

## Verification
The steady level and the enable, polarity and gating paths are combinational from the stored registers and the link inputs. Pins therefore follow a link change in the same cycle and a register write after one edge. An event pulse opens its window at the edge that samples it, so the pin shows blink phase 0 in the following cycle. Later phase steps and the window's close fall on prescaler ticks that the bench counts alongside the design. The bench drives inputs and compares all pins against its own model once per cycle, at the falling clock edge, so every result is looked at in the cycle it becomes due. Reads are compared a short time after the address changes, well before the next rising edge.

// File: rtl/ledrule_pkg.sv
// Package: shared constants and register layout of the indicator controller.
// Assumes 8-bit register addresses and 16-bit register data.
package ledrule_pkg;
    localparam int ADDR_W = 8;
    localparam int DATA_W = 16;

    localparam logic [ADDR_W-1:0] ADDR_CTRL   = 8'h21;
    localparam logic [ADDR_W-1:0] ADDR_ON_T   = 8'h22;
    localparam logic [ADDR_W-1:0] ADDR_PERIOD = 8'h23;
    localparam int                ADDR_RULE0  = 'h24;

    localparam logic [DATA_W-1:0] CTRL_MASK = 16'h800F;
    localparam logic [DATA_W-1:0] STDY_MASK = 16'hC17F;
    localparam logic [DATA_W-1:0] BLNK_MASK = 16'h0FFF;

    localparam logic [DATA_W-1:0] ON_T_RST   = 16'd1024;
    localparam logic [DATA_W-1:0] PERIOD_RST = 16'd2048;

    // control bits
    localparam int C_CLKEN = 3;
    localparam int C_EXT   = 15;

    // steady rule bits
    localparam int S_G1000 = 0;
    localparam int S_M100  = 1;
    localparam int S_M10   = 2;
    localparam int S_DOWN  = 3;
    localparam int S_FDX   = 4;
    localparam int S_HDX   = 5;
    localparam int S_FORCE = 6;
    localparam int S_G2500 = 8;
    localparam int S_POL   = 14;
    localparam int S_EN    = 15;

    // blink rule bits
    localparam int B_COL   = 6;
    localparam int B_CRC   = 7;
    localparam int B_IDLE  = 8;
    localparam int B_FORCE = 9;

    typedef enum logic [1:0] {
        SPD_10   = 2'd0,
        SPD_100  = 2'd1,
        SPD_1000 = 2'd2,
        SPD_2500 = 2'd3
    } speed_e;
endpackage

// File: rtl/ledrule_regs.sv
// Module: register file of the controller. Holds the control, duration and
// per-indicator rule registers, masks unused bits on write and serves reads.
// Assumes one write per cycle; reads are combinational from the address.
module ledrule_regs
    import ledrule_pkg::*;
#(
    parameter int NUM_LED = 3
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            we,
    input  logic [ADDR_W-1:0]               addr,
    input  logic [DATA_W-1:0]               wdata,
    output logic [DATA_W-1:0]               rdata,
    output logic [DATA_W-1:0]               ctrl_q,
    output logic [DATA_W-1:0]               on_t_q,
    output logic [DATA_W-1:0]               period_q,
    output logic [NUM_LED-1:0][DATA_W-1:0]  stdy_q,
    output logic [NUM_LED-1:0][DATA_W-1:0]  blnk_q
);

    // Shared registers: control and the two durations.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q   <= '0;
            on_t_q   <= ON_T_RST;
            period_q <= PERIOD_RST;
        end else if (we) begin
            if (addr == ADDR_CTRL)   ctrl_q   <= wdata & CTRL_MASK;
            if (addr == ADDR_ON_T)   on_t_q   <= wdata;
            if (addr == ADDR_PERIOD) period_q <= wdata;
        end
    end

    // Per-indicator rule registers, one pair per generate slice.
    for (genvar g = 0; g < NUM_LED; g++) begin : g_rule
        localparam logic [ADDR_W-1:0] A_STDY = ADDR_W'(ADDR_RULE0 + 2*g);
        localparam logic [ADDR_W-1:0] A_BLNK = ADDR_W'(ADDR_RULE0 + 2*g + 1);

        // Capture of the steady and blink rule of this indicator.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                stdy_q[g] <= '0;
                blnk_q[g] <= '0;
            end else if (we) begin
                if (addr == A_STDY) stdy_q[g] <= wdata & STDY_MASK;
                if (addr == A_BLNK) blnk_q[g] <= wdata & BLNK_MASK;
            end
        end
    end

    // Read mux: stored value of the addressed register, zero elsewhere.
    always_comb begin
        rdata = '0;
        if (addr == ADDR_CTRL)   rdata = ctrl_q;
        if (addr == ADDR_ON_T)   rdata = on_t_q;
        if (addr == ADDR_PERIOD) rdata = period_q;
        for (int i = 0; i < NUM_LED; i++) begin
            if (addr == ADDR_W'(ADDR_RULE0 + 2*i))     rdata = stdy_q[i];
            if (addr == ADDR_W'(ADDR_RULE0 + 2*i + 1)) rdata = blnk_q[i];
        end
    end

    p_ontime_wr_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (we && addr == ADDR_ON_T) |=> (on_t_q == $past(wdata)));

    p_ctrl_unused_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (we && addr == ADDR_CTRL) |=> ((rdata & ~CTRL_MASK) == '0 || addr != ADDR_CTRL));

endmodule

// File: rtl/ledrule_tick.sv
// Module: prescaler producing the tick that paces blink phases.
// Assumes PRESCALE >= 1; held at its start while the clock enable is low.
module ledrule_tick #(
    parameter int PRESCALE = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int PW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
    localparam logic [PW-1:0] LAST = PW'(PRESCALE - 1);

    logic [PW-1:0] cnt_q;

    // Cycle counter, wraps at PRESCALE-1.
    always_ff @(posedge clk) begin
        if (!rst_n || !run)   cnt_q <= '0;
        else if (cnt_q == LAST) cnt_q <= '0;
        else                  cnt_q <= cnt_q + 1'b1;
    end

    assign tick = run && (cnt_q == LAST);

    if (PRESCALE > 1) begin : g_gap_chk
        p_tick_gap_r11: assert property (@(posedge clk) disable iff (!rst_n)
            tick |=> !tick);
    end
endmodule

// File: rtl/ledrule_lane.sv
// Module: one indicator. Evaluates the steady rule against link state,
// runs the blink window and phase counters, applies gate, enable, polarity.
// Assumes event inputs are single-cycle pulses sampled on the clock.
module ledrule_lane
    import ledrule_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              gate,
    input  logic [DATA_W-1:0] stdy,
    input  logic [DATA_W-1:0] blnk,
    input  logic [DATA_W-1:0] on_t,
    input  logic [DATA_W-1:0] period,
    input  logic              link_up,
    input  logic [1:0]        link_speed,
    input  logic              full_duplex,
    input  logic [3:0]        tx_evt,
    input  logic [3:0]        rx_evt,
    input  logic              col_evt,
    input  logic              crc_err_evt,
    input  logic              idle_err_evt,
    output logic              pin
);
    logic [3:0]        tx_sel, rx_sel;
    logic              spd_hit, steady, hit, blink_lvl, level, lit;
    logic              win_q;
    logic [DATA_W-1:0] wcnt_q, ph_q, ph_nxt;
    logic              wcnt_done;

    // Event selection, indexed by speed code.
    assign tx_sel = {blnk[10], blnk[0], blnk[2], blnk[4]};
    assign rx_sel = {blnk[11], blnk[1], blnk[3], blnk[5]};

    // Steady condition from link state.
    always_comb begin
        unique case (speed_e'(link_speed))
            SPD_10:   spd_hit = stdy[S_M10];
            SPD_100:  spd_hit = stdy[S_M100];
            SPD_1000: spd_hit = stdy[S_G1000];
            default:  spd_hit = stdy[S_G2500];
        endcase
        steady = stdy[S_FORCE]
               | (link_up & (spd_hit | (stdy[S_FDX] & full_duplex)
                                     | (stdy[S_HDX] & ~full_duplex)))
               | (stdy[S_DOWN] & ~link_up);
    end

    assign hit = (|(tx_evt & tx_sel)) | (|(rx_evt & rx_sel))
               | (col_evt & blnk[B_COL]) | (crc_err_evt & blnk[B_CRC])
               | (idle_err_evt & blnk[B_IDLE]) | blnk[B_FORCE];

    assign ph_nxt    = ({1'b0, ph_q} + 17'd1 >= {1'b0, period}) ? '0 : ph_q + 1'b1;
    assign wcnt_done = ({1'b0, wcnt_q} + 17'd1 >= {1'b0, period});

    // Blink window: opened or restarted by a hit, closed after a quiet period.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win_q  <= 1'b0;
            wcnt_q <= '0;
        end else if (hit) begin
            win_q  <= 1'b1;
            wcnt_q <= '0;
        end else if (win_q && tick) begin
            wcnt_q <= wcnt_q + 1'b1;
            if (wcnt_done) win_q <= 1'b0;
        end
    end

    // Blink phase: restarts when a window opens, steps on ticks inside it.
    always_ff @(posedge clk) begin
        if (!rst_n)                ph_q <= '0;
        else if (hit && !win_q)    ph_q <= '0;
        else if (win_q && tick)    ph_q <= ph_nxt;
    end

    assign blink_lvl = (ph_q < on_t);
    assign level     = win_q ? blink_lvl : steady;
    assign lit       = stdy[S_EN] & gate & level;
    assign pin       = stdy[S_POL] ? lit : ~lit;

    p_win_open_r6: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> win_q);

    p_dark_phase_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (win_q && ph_q >= on_t) |-> (pin == ~stdy[S_POL]));

    p_force_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (blnk[B_FORCE] && $stable(blnk)) |=> win_q);
endmodule

// File: rtl/ledrule_ctrl.sv
// Module: top of the indicator controller. Ties the register file, the
// tick prescaler and one lane per indicator together.
// Assumes a single clock domain for register access and status inputs.
module ledrule_ctrl
    import ledrule_pkg::*;
#(
    parameter int NUM_LED  = 3,
    parameter int PRESCALE = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_we,
    input  logic [7:0]         reg_addr,
    input  logic [15:0]        reg_wdata,
    output logic [15:0]        reg_rdata,
    input  logic               link_up,
    input  logic [1:0]         link_speed,
    input  logic               full_duplex,
    input  logic [3:0]         tx_evt,
    input  logic [3:0]         rx_evt,
    input  logic               col_evt,
    input  logic               crc_err_evt,
    input  logic               idle_err_evt,
    output logic [NUM_LED-1:0] led_pin
);
    logic [DATA_W-1:0]              ctrl_q, on_t_q, period_q;
    logic [NUM_LED-1:0][DATA_W-1:0] stdy_q, blnk_q;
    logic                           tick, gate;
    logic [NUM_LED-1:0]             idle_lvl;

    ledrule_regs #(.NUM_LED(NUM_LED)) u_regs (
        .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr),
        .wdata(reg_wdata), .rdata(reg_rdata), .ctrl_q(ctrl_q),
        .on_t_q(on_t_q), .period_q(period_q), .stdy_q(stdy_q), .blnk_q(blnk_q)
    );

    ledrule_tick #(.PRESCALE(PRESCALE)) u_tick (
        .clk(clk), .rst_n(rst_n), .run(ctrl_q[C_CLKEN]), .tick(tick)
    );

    assign gate = ctrl_q[C_EXT] & ctrl_q[C_CLKEN];

    for (genvar g = 0; g < NUM_LED; g++) begin : g_lane
        ledrule_lane u_lane (
            .clk(clk), .rst_n(rst_n), .tick(tick), .gate(gate),
            .stdy(stdy_q[g]), .blnk(blnk_q[g]), .on_t(on_t_q), .period(period_q),
            .link_up(link_up), .link_speed(link_speed), .full_duplex(full_duplex),
            .tx_evt(tx_evt), .rx_evt(rx_evt), .col_evt(col_evt),
            .crc_err_evt(crc_err_evt), .idle_err_evt(idle_err_evt),
            .pin(led_pin[g])
        );
        assign idle_lvl[g] = ~stdy_q[g][S_POL];
    end

    p_gate_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(ctrl_q[C_EXT] && ctrl_q[C_CLKEN]) |-> (led_pin == idle_lvl));
endmodule

// File: tb/ledrule_ctrl_bench.sv
`timescale 1ns/1ps
module ledrule_ctrl_bench;
    localparam int NL  = 3;
    localparam int PRE = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        link_up = 1'b0;
    logic [1:0]  link_speed = '0;
    logic        full_duplex = 1'b0;
    logic [3:0]  tx_evt = '0, rx_evt = '0;
    logic        col_evt = 1'b0, crc_err_evt = 1'b0, idle_err_evt = 1'b0;
    logic [NL-1:0] led_pin;

    int n_chk = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    ledrule_ctrl #(.NUM_LED(NL), .PRESCALE(PRE)) u_ledrule_ctrl (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .link_up(link_up),
        .link_speed(link_speed), .full_duplex(full_duplex), .tx_evt(tx_evt),
        .rx_evt(rx_evt), .col_evt(col_evt), .crc_err_evt(crc_err_evt),
        .idle_err_evt(idle_err_evt), .led_pin(led_pin)
    );

    // ---------------- reference model built from the requirements ----------
    logic [15:0] m_ctrl, m_ont, m_per;
    logic [15:0] m_st [NL];
    logic [15:0] m_bl [NL];
    int          m_pre;
    bit          m_win [NL];
    int          m_wc [NL];
    int          m_ph [NL];

    function automatic bit m_hit(int i);
        logic [15:0] b = m_bl[i];
        logic [3:0] ts = {b[10], b[0], b[2], b[4]};
        logic [3:0] rs = {b[11], b[1], b[3], b[5]};
        return (|(tx_evt & ts)) || (|(rx_evt & rs)) || (col_evt && b[6]) ||
               (crc_err_evt && b[7]) || (idle_err_evt && b[8]) || b[9];
    endfunction

    function automatic bit m_pin(int i);
        logic [15:0] s = m_st[i];
        bit sp, stdy, lvl, lit;
        case (link_speed)
            2'd0: sp = s[2];
            2'd1: sp = s[1];
            2'd2: sp = s[0];
            default: sp = s[8];
        endcase
        stdy = s[6] || (link_up && (sp || (s[4] && full_duplex) || (s[5] && !full_duplex)))
                    || (s[3] && !link_up);
        lvl = m_win[i] ? (m_ph[i] < int'(m_ont)) : stdy;
        lit = s[15] && m_ctrl[15] && m_ctrl[3] && lvl;
        return s[14] ? lit : !lit;
    endfunction

    always @(posedge clk) begin
        bit tk, h;
        if (!rst_n) begin
            m_ctrl = '0; m_ont = 16'd1024; m_per = 16'd2048; m_pre = 0;
            for (int i = 0; i < NL; i++) begin
                m_st[i] = '0; m_bl[i] = '0; m_win[i] = 0; m_wc[i] = 0; m_ph[i] = 0;
            end
        end else begin
            tk = m_ctrl[3] && (m_pre == PRE - 1);
            for (int i = 0; i < NL; i++) begin
                h = m_hit(i);
                if (h) begin
                    if (!m_win[i]) m_ph[i] = 0;
                    else if (tk) m_ph[i] = (m_ph[i] + 1 >= int'(m_per)) ? 0 : m_ph[i] + 1;
                    m_win[i] = 1; m_wc[i] = 0;
                end else if (m_win[i] && tk) begin
                    if (m_wc[i] + 1 >= int'(m_per)) m_win[i] = 0;
                    m_wc[i] = m_wc[i] + 1;
                    m_ph[i] = (m_ph[i] + 1 >= int'(m_per)) ? 0 : m_ph[i] + 1;
                end
            end
            if (!m_ctrl[3]) m_pre = 0;
            else m_pre = (m_pre == PRE - 1) ? 0 : m_pre + 1;
            if (reg_we) begin
                if (reg_addr == 8'h21) m_ctrl = reg_wdata & 16'h800F;
                if (reg_addr == 8'h22) m_ont = reg_wdata;
                if (reg_addr == 8'h23) m_per = reg_wdata;
                for (int i = 0; i < NL; i++) begin
                    if (reg_addr == 8'(8'h24 + 2*i)) m_st[i] = reg_wdata & 16'hC17F;
                    if (reg_addr == 8'(8'h25 + 2*i)) m_bl[i] = reg_wdata & 16'h0FFF;
                end
            end
        end
    end

    // ---------------- check helpers -----------------------------------------
    task automatic chk(bit ok, string tag, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic step(string tag);
        @(negedge clk);
        for (int i = 0; i < NL; i++)
            chk(led_pin[i] == m_pin(i), tag, int'(led_pin[i]), int'(m_pin(i)));
    endtask

    task automatic wr(logic [7:0] a, logic [15:0] d);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        step("R1 write");
        reg_we = 1'b0;
    endtask

    task automatic rd(logic [7:0] a, logic [15:0] e, string tag);
        reg_addr = a;
        #1;
        chk(reg_rdata == e, tag, int'(reg_rdata), int'(e));
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: run did not finish (all requirements) actual 1 expected 0");
        summary();
        $finish;
    end

    // ---------------- stimulus ------------------------------------------------
    initial begin
        int rises, flips;
        bit prev;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        step("R2");
        // R2: reset values and inactive pins
        chk(led_pin == 3'b111, "R2 pins", int'(led_pin), 7);
        rd(8'h21, 16'h0000, "R2 ctrl");
        rd(8'h22, 16'd1024, "R2 on time");
        rd(8'h23, 16'd2048, "R2 period");
        rd(8'h24, 16'h0000, "R2 rule");
        rd(8'h29, 16'h0000, "R2 rule");

        // R1: masks and decode
        wr(8'h21, 16'hFFFF); rd(8'h21, 16'h800F, "R1 ctrl mask");
        wr(8'h24, 16'hFFFF); rd(8'h24, 16'hC17F, "R1 steady mask");
        wr(8'h25, 16'hFFFF); rd(8'h25, 16'h0FFF, "R1 blink mask");
        wr(8'h22, 16'hBEEF); rd(8'h22, 16'hBEEF, "R1 on time");
        rd(8'h2A, 16'h0000, "R1 unmapped");
        rd(8'h20, 16'h0000, "R1 unmapped");
        wr(8'h25, 16'h0000); wr(8'h24, 16'h0000); wr(8'h21, 16'h0000);
        wr(8'h22, 16'd1024);
        repeat (30) step("R8 settle");

        // R3 / R5: global gate and force on
        wr(8'h24, 16'hC040);
        wr(8'h21, 16'h0008); step("R3"); chk(led_pin[0] == 1'b0, "R3 ext off", int'(led_pin[0]), 0);
        wr(8'h21, 16'h8000); step("R3"); chk(led_pin[0] == 1'b0, "R3 clk off", int'(led_pin[0]), 0);
        wr(8'h21, 16'h8008); step("R5"); chk(led_pin[0] == 1'b1, "R5 force on", int'(led_pin[0]), 1);

        // R10: polarity and enable
        wr(8'h24, 16'h8040); step("R10"); chk(led_pin[0] == 1'b0, "R10 active low", int'(led_pin[0]), 0);
        wr(8'h24, 16'h4040); step("R10"); chk(led_pin[0] == 1'b0, "R10 disabled high pol", int'(led_pin[0]), 0);
        wr(8'h24, 16'h0040); step("R10"); chk(led_pin[0] == 1'b1, "R10 disabled low pol", int'(led_pin[0]), 1);
        wr(8'h24, 16'h0000);

        // R4: steady link conditions
        wr(8'h26, 16'hC001); link_up = 1; link_speed = 2'd2;
        step("R4"); chk(led_pin[1] == 1'b1, "R4 1000 match", int'(led_pin[1]), 1);
        link_speed = 2'd1; step("R4"); chk(led_pin[1] == 1'b0, "R4 100 no match", int'(led_pin[1]), 0);
        link_speed = 2'd3; wr(8'h26, 16'hC100);
        step("R4"); chk(led_pin[1] == 1'b1, "R4 2500 match", int'(led_pin[1]), 1);
        link_up = 0; step("R4"); chk(led_pin[1] == 1'b0, "R4 link down", int'(led_pin[1]), 0);
        wr(8'h26, 16'hC008); step("R4"); chk(led_pin[1] == 1'b1, "R4 down rule", int'(led_pin[1]), 1);
        link_up = 1; full_duplex = 1; wr(8'h26, 16'hC010);
        step("R4"); chk(led_pin[1] == 1'b1, "R4 full duplex", int'(led_pin[1]), 1);
        full_duplex = 0; step("R4"); chk(led_pin[1] == 1'b0, "R4 half no match", int'(led_pin[1]), 0);
        wr(8'h26, 16'h0000);

        // R6 / R7 / R8: event selection and window timing
        wr(8'h22, 16'd2); wr(8'h23, 16'd4); wr(8'h28, 16'hC000); wr(8'h29, 16'h0008);
        rx_evt = 4'b0100; step("R6"); rx_evt = 4'b0000;
        repeat (5) step("R6");
        chk(led_pin[2] == 1'b0, "R6 unselected event", int'(led_pin[2]), 0);
        rx_evt = 4'b0010; step("R7"); rx_evt = 4'b0000;
        chk(led_pin[2] == 1'b1, "R7 window opens lit", int'(led_pin[2]), 1);
        repeat (30) step("R8");
        chk(led_pin[2] == 1'b0, "R8 window closed", int'(led_pin[2]), 0);
        wr(8'h29, 16'h0040);
        col_evt = 1; step("R6"); col_evt = 0;
        chk(led_pin[2] == 1'b1, "R6 collision selected", int'(led_pin[2]), 1);
        repeat (30) step("R8");

        // R9 / R11: force blink held open, tick spacing
        wr(8'h22, 16'd1); wr(8'h23, 16'd2); wr(8'h29, 16'h0200);
        repeat (100) step("R9");
        flips = 0; rises = 0; prev = led_pin[2];
        for (int k = 0; k < 60; k++) begin
            step("R11");
            if (led_pin[2] != prev) flips++;
            if (led_pin[2] && !prev) rises++;
            prev = led_pin[2];
        end
        chk(flips > 0, "R9 still blinking", flips, 20);
        chk(rises == 10, "R11 blink period", rises, 10);
        wr(8'h29, 16'h0000);

        // Random phase, checked every cycle against the model
        for (int k = 0; k < 4000; k++) begin
            if ($urandom_range(49) == 0) begin
                int a = $urandom_range(8'h29, 8'h21);
                logic [15:0] d = 16'($urandom);
                if (a == 'h21) d = ($urandom_range(3) == 0) ? 16'h0008 : 16'h8008;
                else if (a == 'h22 || a == 'h23) d = 16'($urandom_range(7));
                else if (a[0] == 0) d[15] = ($urandom_range(3) != 0);
                else d[9] = ($urandom_range(7) == 0);
                wr(8'(a), d);
            end else begin
                if ($urandom_range(15) == 0) link_up = ~link_up;
                if ($urandom_range(31) == 0) link_speed = 2'($urandom);
                if ($urandom_range(31) == 0) full_duplex = ~full_duplex;
                tx_evt = 4'($urandom) & 4'($urandom) & 4'($urandom);
                rx_evt = 4'($urandom) & 4'($urandom) & 4'($urandom);
                col_evt = ($urandom_range(9) == 0);
                crc_err_evt = ($urandom_range(9) == 0);
                idle_err_evt = ($urandom_range(9) == 0);
                step("R4 R6 R7 R8 R10 random");
            end
        end
        summary();
        $finish;
    end
endmodule